// File: doc/BRIEF.md
# MDIO Station-Management Master

This block is a register-mapped station-management master for an Ethernet PHY. Software first loads a 16-bit data register when it wants to write. It then writes a command word. The command word has a read flag, a write flag, a 5-bit PHY address and a 5-bit register number. The block answers by raising a busy flag. It then shifts one clause-22 management frame out on MDIO, timed by an MDC clock that it divides down from the system clock. Software polls the busy flag. When the flag drops after a read, the 16 bits returned by the PHY are in the data register.

A control register holds two settings: the MDC divisor (stored as divisor minus one) and a switch that leaves out the 32-bit preamble of ones. The MDIO pin is modelled as three plain signals: an output value, an output enable and an input. While the PHY drives the line (turnaround and data of a read), the output enable is released. The input is sampled on each rising MDC edge.

The register bus has no back-pressure. Every write is taken in the cycle it is presented, and read data is a combinational function of the address. A command that cannot be accepted is dropped without a trace rather than stalled.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset: status reads 0, the data register reads 0, and the control register reads the reset divisor field (39 at bits 16:9) with bit 8 clear. MDC is low and MDIO is driven high.
- R2: Register offsets are 0 command, 1 data, 2 status, 3 control. A command write starts a read when bits 15:14 are 10 and a write when they are 01. Bits 9:5 carry the PHY address and bits 4:0 the register number. The values 11 and 00 start nothing. Reading the command register returns the last accepted command in the same bit positions.
- R3: Status bit 0 reads 1 from the first cycle after the clock edge that accepts a command, and reads 0 once the last frame bit has completed.
- R4: A command written while status bit 0 is 1 is ignored: the frame in flight continues unchanged, no second frame follows, and the command register keeps the accepted command.
- R5: A write frame is 64 MDC rising edges, sent MSB first: 32 ones, 01, 01, PHY address, register number, 10, then the 16 data bits.
- R6: A read frame sends 32 ones, 01, 10, PHY address and register number. For the last 18 bit periods (turnaround and data) the output enable is 0. The input is sampled at each of the last 16 rising MDC edges, MSB first, and the 16-bit result reads from the data register once status bit 0 is 0.
- R7: With control bit 8 set, the 32 preamble bits are omitted and a frame is 32 MDC rising edges long.
- R8: The MDC period is field+1 system clocks, with field 0 treated as 2. MDC is high for floor(period/2) clocks of each period and stays low while idle.
- R9: The MDIO output value and enable change only while MDC is low.
- R10: While idle, the output enable is 1 and the MDIO output is 1.
- R11: Data register writes (bits 15:0) and control register writes (divisor field at bits 16:9, suppression at bit 8) read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, 1 = drive |
| mdio_i | input | 1 | MDIO line value as seen at the pin |

## Verification
The bench builds the block with its default parameters: an 8-bit divisor field and a reset divisor of 40. The first frame runs at that reset value, which exercises a long 20/20 MDC duty at the default setting. The bench then reprograms the divisor to 4, to 5 and to field value 0. These reach the symmetric case, the odd divisor whose low phase is one clock longer than its high phase, and the clamp to a two-clock period. At the two-clock period, sampling and shifting fall on the same clock. The suppressed-preamble read and write run at that fastest rate, so the final data bit is captured in the same cycle the frame ends.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS   = 64;
  localparam int PRE_BITS     = 32;
  localparam int DATA_BITS    = 16;
  localparam int RELEASE_BITS = 18;
  localparam int CNT_W        = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_BOTH  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    A_CMD  = 2'd0,
    A_DATA = 2'd1,
    A_STAT = 2'd2,
    A_CTRL = 2'd3
  } addr_e;

  typedef struct packed {
    op_e        op;
    logic [4:0] phy;
    logic [4:0] regn;
  } cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_m1,
  input  logic             run,
  output logic             mdc,
  output logic             rise,
  output logic             last
);
  localparam int PW = DIV_W + 1;

  logic [PW-1:0] per_q;
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] low_len;

  // low phase takes the extra clock of an odd period
  assign low_len = per_q - (per_q >> 1);
  assign mdc     = run && (cnt_q >= low_len);
  assign rise    = run && (cnt_q == low_len);
  assign last    = run && (cnt_q == per_q - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= PW'(2);
      cnt_q <= '0;
    end else if (load) begin
      per_q <= (div_m1 == '0) ? PW'(2) : PW'(div_m1) + PW'(1);
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= last ? '0 : cnt_q + PW'(1);
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  cmd_t             cmd,
  input  logic [15:0]      wdata,
  input  logic             sup,
  input  logic             rise,
  input  logic             last,
  input  logic             mdio_i,
  output logic             busy,
  output logic [CNT_W-1:0] left,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             done,
  output logic [15:0]      rx_word
);
  logic [FRAME_BITS-1:0] sr_q;
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      left_q;
  logic                  busy_q;
  logic                  rd_q;
  logic [15:0]           rx_q;
  logic [15:0]           rx_nxt;
  logic [1:0]            ta;

  assign ta    = (cmd.op == OP_READ) ? 2'b11 : 2'b10;
  assign frame = {{PRE_BITS{1'b1}}, 2'b01, cmd.op, cmd.phy, cmd.regn, ta, wdata};

  assign rx_nxt = (busy_q && rd_q && rise && (left_q <= CNT_W'(DATA_BITS)))
                ? {rx_q[14:0], mdio_i} : rx_q;

  assign done    = busy_q && last && (left_q == CNT_W'(1));
  assign busy    = busy_q;
  assign left    = left_q;
  assign rx_word = rx_nxt;
  assign mdio_o  = busy_q ? sr_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe = busy_q ? !(rd_q && (left_q <= CNT_W'(RELEASE_BITS))) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      rx_q   <= '0;
    end else if (start) begin
      sr_q   <= sup ? {frame[FRAME_BITS-PRE_BITS-1:0], {PRE_BITS{1'b0}}} : frame;
      left_q <= sup ? CNT_W'(FRAME_BITS - PRE_BITS) : CNT_W'(FRAME_BITS);
      busy_q <= 1'b1;
      rd_q   <= (cmd.op == OP_READ);
      rx_q   <= '0;
    end else if (busy_q) begin
      rx_q <= rx_nxt;
      if (last) begin
        sr_q   <= sr_q << 1;
        left_q <= left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int RST_DIV_M1 = 39
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             busy,
  input  logic             done,
  input  logic [15:0]      rx_word,
  output logic             start,
  output cmd_t             cmd_new,
  output logic [15:0]      data,
  output logic             sup,
  output logic [DIV_W-1:0] div_m1
);
  localparam int DIV_LSB = 9;
  localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

  cmd_t             cmd_q;
  logic [15:0]      data_q;
  logic [DIV_W-1:0] div_q;
  logic             sup_q;
  op_e              req_op;
  logic             unused_bits;

  assign unused_bits = ^{bus_wdata[31:DIV_MSB+1], bus_wdata[13:10]};

  assign req_op  = op_e'(bus_wdata[15:14]);
  assign cmd_new = '{op: req_op, phy: bus_wdata[9:5], regn: bus_wdata[4:0]};
  assign start   = bus_wr && (addr_e'(bus_addr) == A_CMD) && !busy &&
                   ((req_op == OP_READ) || (req_op == OP_WRITE));
  assign data    = data_q;
  assign sup     = sup_q;
  assign div_m1  = div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '{op: OP_NONE, phy: 5'd0, regn: 5'd0};
      data_q <= '0;
      div_q  <= DIV_W'(RST_DIV_M1);
      sup_q  <= 1'b0;
    end else begin
      if (start) cmd_q <= cmd_new;
      if (done && (cmd_q.op == OP_READ))
        data_q <= rx_word;
      else if (bus_wr && (addr_e'(bus_addr) == A_DATA))
        data_q <= bus_wdata[15:0];
      if (bus_wr && (addr_e'(bus_addr) == A_CTRL)) begin
        div_q <= bus_wdata[DIV_MSB:DIV_LSB];
        sup_q <= bus_wdata[8];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (addr_e'(bus_addr))
      A_CMD: begin
        bus_rdata[15:14] = cmd_q.op;
        bus_rdata[9:5]   = cmd_q.phy;
        bus_rdata[4:0]   = cmd_q.regn;
      end
      A_DATA: bus_rdata[15:0] = data_q;
      A_STAT: bus_rdata[0] = busy;
      A_CTRL: begin
        bus_rdata[DIV_MSB:DIV_LSB] = div_q;
        bus_rdata[8]               = sup_q;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int RST_DIV_M1 = 39
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic             start;
  cmd_t             cmd_new;
  logic [15:0]      data;
  logic             sup;
  logic [DIV_W-1:0] div_m1;
  logic             busy;
  logic [CNT_W-1:0] bits_left;
  logic             done;
  logic [15:0]      rx_word;
  logic             rise;
  logic             last;

  mdio_regs #(.DIV_W(DIV_W), .RST_DIV_M1(RST_DIV_M1)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(reg_wr), .bus_addr(reg_addr), .bus_wdata(reg_wdata), .bus_rdata(reg_rdata),
    .busy(busy), .done(done), .rx_word(rx_word),
    .start(start), .cmd_new(cmd_new), .data(data), .sup(sup), .div_m1(div_m1)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .load(start), .div_m1(div_m1), .run(busy),
    .mdc(mdc), .rise(rise), .last(last)
  );

  mdio_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd_new), .wdata(data), .sup(sup),
    .rise(rise), .last(last), .mdio_i(mdio_i),
    .busy(busy), .left(bits_left), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(done), .rx_word(rx_word)
  );
endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [1:0] cmd_bits,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       busy,
  input logic [6:0] bits_left
);
  logic cmd_wr;
  assign cmd_wr = reg_wr && (reg_addr == 2'd0);

  a_r3_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && (cmd_bits[1] ^ cmd_bits[0])) |=> busy);

  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> (!busy || bits_left == $past(bits_left) ||
                          bits_left == $past(bits_left) - 7'd1));

  a_r6_release_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mdio_oe) |=> (!busy || !mdio_oe));

  a_r8_mdc_low_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !mdc);

  a_r9_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  a_r10_idle_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mdio_oe && mdio_o && !mdc));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .cmd_bits(reg_wdata[15:14]), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .bits_left(bits_left)
);

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;
  int total_n = 0;
  int bad_n = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdio_mgmt_ctrl i_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total_n++;
    if (!ok) begin
      bad_n++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run_frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [15:0] phy_word, input bit sup,
                           input int inject, input string tag, input int exp_per, input int exp_hi);
    int total;
    logic [63:0] exp_frame, cap, oecap, mask, oe_exp;
    int nrise, first_rise, second_rise, hi, guard;
    bit prev_m, m, busy_b, hi_done, inj_done, inj_now, stable_ok, held, rdflag;
    logic [31:0] d;
    total = sup ? 32 : 64;
    rdflag = (op == 2'b10);
    cap = '0; oecap = '0; nrise = 0; first_rise = -1; second_rise = -1; hi = 0; guard = 0;
    prev_m = 0; hi_done = 0; inj_done = 0; inj_now = 0; stable_ok = 1; held = 1;
    exp_frame = {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, wd};
    if (!rdflag) wr(2'd1, {16'h0, wd});
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = {16'h0, op, 4'h0, phy, rg};
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd2;
    #1 chk(reg_rdata[0] == 1'b1, {tag, " R3 busy after accept"}, reg_rdata[0], 1);
    while (1) begin
      busy_b = (reg_addr == 2'd2) ? reg_rdata[0] : 1'b1;
      m = mdc;
      if (m && !prev_m) begin
        cap = {cap[62:0], mdio_o};
        oecap = {oecap[62:0], mdio_oe};
        held = mdio_o;
        nrise++;
        if (first_rise < 0) first_rise = cyc;
        else if (second_rise < 0) second_rise = cyc;
      end else if (m && prev_m && mdio_o !== held) begin
        stable_ok = 0;
      end
      if (m && first_rise >= 0 && !hi_done) hi++;
      if (!m && first_rise >= 0) hi_done = 1;
      if (!m) mdio_i = (nrise >= total - 16 && nrise < total) ?
                       phy_word[15 - (nrise - (total - 16))] : 1'b1;
      prev_m = m;
      if (inj_now) begin
        reg_wr = 1'b0; reg_addr = 2'd2; inj_now = 0;
      end else if (inject >= 0 && !inj_done && nrise == inject && !m) begin
        reg_wr = 1'b1; reg_addr = 2'd0;
        reg_wdata = {16'h0, 2'b10, 4'h0, ~phy, ~rg};
        inj_done = 1; inj_now = 1;
      end
      if (!busy_b) break;
      guard++;
      if (guard > 20000) begin
        chk(0, {tag, " R3 busy never cleared"}, 1, 0);
        break;
      end
      @(negedge clk);
    end
    mdio_i = 1'b1;
    mask = (total == 64) ? '1 : ((64'd1 << total) - 64'd1);
    oe_exp = mask;
    if (rdflag) begin
      mask = mask & ~64'h3_FFFF;
      oe_exp = oe_exp & ~64'h3_FFFF;
    end
    chk(nrise == total, {tag, " R5/R7 rising edge count"}, nrise, total);
    chk((cap & mask) == (exp_frame & mask), {tag, rdflag ? " R6 read bits" : " R5 write bits"},
        cap & mask, exp_frame & mask);
    chk(oecap == oe_exp, {tag, " R6 output enable per bit"}, oecap, oe_exp);
    chk(stable_ok, {tag, " R9 mdio stable while mdc high"}, stable_ok, 1);
    if (exp_per > 0) begin
      chk(second_rise - first_rise == exp_per, {tag, " R8 mdc period"},
          second_rise - first_rise, exp_per);
      chk(hi == exp_hi, {tag, " R8 mdc high time"}, hi, exp_hi);
    end
    #1 chk(mdc == 1'b0 && mdio_oe == 1'b1 && mdio_o == 1'b1, {tag, " R10 idle pin"},
           {mdc, mdio_oe, mdio_o}, 3'b011);
    if (rdflag) begin
      rd(2'd1, d);
      chk(d[15:0] == phy_word, {tag, " R6 read data"}, d[15:0], phy_word);
    end
    rd(2'd0, d);
    chk(d == {16'h0, op, 4'h0, phy, rg}, {tag, " R2 command readback"}, d, {16'h0, op, 4'h0, phy, rg});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd2, d); chk(d == 32'h0, "R1 status", d, 0);
    rd(2'd1, d); chk(d == 32'h0, "R1 data", d, 0);
    rd(2'd3, d); chk(d == (32'd39 << 9), "R1 control", d, 32'd39 << 9);
    chk(mdc == 1'b0, "R1 mdc low", mdc, 0);
    chk(mdio_oe && mdio_o, "R10 idle drive high", {mdio_oe, mdio_o}, 2'b11);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(2'd1, 32'h0000_A5C3);
    rd(2'd1, d); chk(d == 32'h0000_A5C3, "R11 data readback", d, 32'hA5C3);
    wr(2'd3, (32'd200 << 9) | 32'h100);
    rd(2'd3, d); chk(d == ((32'd200 << 9) | 32'h100), "R11 control readback", d, (32'd200 << 9) | 32'h100);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] d;
    run_frame(2'b01, 5'h0A, 5'h15, 16'h1234, 16'h0, 1'b0, 5, "ignore", 4, 2);
    repeat (20) @(negedge clk);
    rd(2'd2, d); chk(d[0] == 1'b0, "R4 no second frame", d[0], 0);
    chk(mdc == 1'b0, "R4 mdc quiet after frame", mdc, 0);
  endtask

  task automatic t_bad_cmd;
    logic [31:0] d;
    wr(2'd0, 32'h0000_C000 | (32'd3 << 5) | 32'd7);
    rd(2'd2, d); chk(d[0] == 1'b0, "R2 both flags start nothing", d[0], 0);
    wr(2'd0, (32'd3 << 5) | 32'd7);
    rd(2'd2, d); chk(d[0] == 1'b0, "R2 no flag starts nothing", d[0], 0);
    rd(2'd0, d);
    chk(d == {16'h0, 2'b01, 4'h0, 5'h0A, 5'h15}, "R2 command kept", d,
        {16'h0, 2'b01, 4'h0, 5'h0A, 5'h15});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total_n++; bad_n++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_frame(2'b01, 5'h11, 5'h04, 16'hBEEF, 16'h0, 1'b0, -1, "default div write", 40, 20);
    t_regs();
    wr(2'd3, 32'd3 << 9);
    run_frame(2'b01, 5'h1F, 5'h00, 16'h8001, 16'h0, 1'b0, -1, "write", 4, 2);
    wr(2'd3, 32'd4 << 9);
    run_frame(2'b10, 5'h05, 5'h1A, 16'h0, 16'hC35A, 1'b0, -1, "read", 5, 2);
    wr(2'd3, 32'h100);
    run_frame(2'b01, 5'h02, 5'h09, 16'h5A0F, 16'h0, 1'b1, -1, "sup write", 2, 1);
    run_frame(2'b10, 5'h13, 5'h0C, 16'h0, 16'h9E71, 1'b1, -1, "sup read", 2, 1);
    wr(2'd3, 32'd3 << 9);
    t_busy_ignore();
    t_bad_cmd();
    $display("test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end
endmodule